// File: doc/BRIEF.md
# DRAM Self-Refresh Sleep Sequencer

This block moves an asynchronous DRAM into its self-refresh state while the host sleeps and brings it back into normal operation on wake. It drives the row strobe, column strobe and write enable, and does not touch the address or data pins. A sleep request that arrives while the block is idle is accepted. The block then pulls the column strobe low and, a fixed number of cycles later, the row strobe. This is CAS-before-RAS order. Both strobes stay low for at least a minimum self-refresh time. While they are low the device refreshes itself, and the block issues no refresh cycles of its own.

The work done around the sleep period depends on how the system refreshes the DRAM. This is chosen by a mode input, which is latched when sleep is accepted.

- **Distributed mode:** the system spreads CBR refreshes evenly. The block issues one CBR refresh right after leaving self-refresh.
- **Burst mode:** the system refreshes in bursts or uses row-only refresh. The block issues a full set of row refreshes (one per row) just before entering self-refresh and again just after leaving it.

On exit, both strobes rise together and stay high for an exit precharge time before any further cycle. When the block is idle again, it pulses a restart signal for one cycle. The periodic refresh scheduler uses this pulse to restart its interval count, so its next refresh comes a full interval later.

Top module: `sr_sleep_seq`

## Requirements
- R1: After reset ras_n, cas_n and we_n are high (1), awake is 1, asleep is 0 and ref_restart is 0.
- R2: In distributed mode (burst_mode=0 when sleep_req is sampled in the idle state), cas_n goes low in the first cycle after acceptance. ras_n stays high for CSR_CYC cycles and then goes low with cas_n still low.
- R3: In burst mode (burst_mode=1 at acceptance), ROWS CBR refreshes run before the entry sequence of R2. Each refresh is CSR_CYC cycles of cas_n=0/ras_n=1, then RAS_CYC cycles of both strobes low, then RP_CYC cycles of both high.
- R4: Once both strobes are low for self-refresh, they stay low for at least SR_MIN_CYC cycles. A wake_req sampled earlier (after sleep acceptance) is held pending and takes effect as soon as that time has elapsed.
- R5: A wake_req sampled after the minimum time has elapsed ends the hold in the next cycle.
- R6: On exit, ras_n and cas_n rise in the same cycle and both stay high for XRP_CYC cycles before any further strobe activity.
- R7: In distributed mode exactly one CBR refresh, timed as in R3, follows the exit precharge.
- R8: In burst mode ROWS CBR refreshes, timed as in R3, follow the exit precharge.
- R9: asleep is 1 exactly during the self-refresh hold, and both strobes are low whenever it is 1. awake is 1 only in the idle state, where both strobes are high.
- R10: ref_restart is 1 for exactly one cycle, the first idle cycle after the exit refresh work.
- R11: we_n is 1 in every cycle.
- R12: The following are ignored:
  - sleep_req outside the idle state;
  - wake_req sampled while idle, which creates no pending wake;
  - changes of burst_mode after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sleep_req | input | 1 | Host request to enter self-refresh, sampled in the idle state |
| wake_req | input | 1 | Host request to leave self-refresh |
| burst_mode | input | 1 | 1 selects full refresh bursts around sleep; 0 selects a single CBR refresh after exit |
| ras_n | output | 1 | Row strobe to the DRAM, active low |
| cas_n | output | 1 | Column strobe to the DRAM (both byte strobes), active low |
| we_n | output | 1 | Write enable to the DRAM, held high |
| asleep | output | 1 | DRAM is in self-refresh |
| awake | output | 1 | DRAM is available for normal cycles |
| ref_restart | output | 1 | One-cycle pulse telling the refresh scheduler to restart its interval |

## Verification
Every output is a function of registered state, so an input sampled at an edge first shows on the pins in the cycle that follows that edge. The first cycle of the entry sequence or refresh burst appears right after acceptance. The hold ends exactly SR_MIN_CYC cycles after the strobes fell, or one cycle after a later wake. The exit refresh starts XRP_CYC cycles after that, and the restart pulse comes in the cycle after the last precharge cycle of the final refresh. For each scenario the bench builds the full expected pin trace from these cycle counts and from the chosen wake cycle. It then compares all six outputs 2 ns after every rising edge. The wake cycles are chosen one before, at and one after the end of the minimum hold, to cover the pending-wake boundary.

// File: rtl/sr_pkg.sv
// Shared types for the self-refresh sleep sequencer.
package sr_pkg;
    // Top-level sequence state.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE_BURST,
        ST_ENTER,
        ST_HOLD,
        ST_EXIT_PRE,
        ST_POST_REF
    } sr_state_t;

    // Phase inside one CBR refresh.
    typedef enum logic [1:0] {
        CB_IDLE,
        CB_CAS_LEAD,
        CB_BOTH_LOW,
        CB_PRECHG
    } cbr_phase_t;
endpackage

// File: rtl/sr_timer.sv
// Down-counter used for every fixed duration in the sequencer.
// Assumes: load takes priority; the count stops at zero; zero is flagged combinationally.
module sr_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] value,
    output logic         zero
);
    logic [W-1:0] cnt;

    // Load a new duration or count down towards zero.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= value;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/sr_cbr_engine.sv
// Issues a run of CBR refresh cycles on the strobes.
// Each refresh: CAS low alone, then both low, then both high (precharge).
// Assumes: start is only raised while the engine is idle; num is the refresh count minus one.
// done is high in the last precharge cycle of the last refresh.
module sr_cbr_engine
    import sr_pkg::*;
#(
    parameter int ROWS    = 1024,
    parameter int CSR_CYC = 1,
    parameter int RAS_CYC = 5,
    parameter int RP_CYC  = 3,
    localparam int RW     = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int MAXD   = (CSR_CYC > RAS_CYC) ? ((CSR_CYC > RP_CYC) ? CSR_CYC : RP_CYC)
                                                : ((RAS_CYC > RP_CYC) ? RAS_CYC : RP_CYC),
    localparam int TW     = $clog2(MAXD + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [RW-1:0] num,
    output logic          ras_n,
    output logic          cas_n,
    output logic          done
);
    cbr_phase_t    phase, phase_nx;
    logic [RW-1:0] left;
    logic          t_load, t_zero;
    logic [TW-1:0] t_val;

    sr_timer #(.W(TW)) u_tmr (
        .clk(clk), .rst_n(rst_n), .load(t_load), .value(t_val), .zero(t_zero)
    );

    // Phase sequencing and timer loads for one refresh.
    always_comb begin
        phase_nx = phase;
        t_load   = 1'b0;
        t_val    = '0;
        done     = 1'b0;
        unique case (phase)
            CB_IDLE: if (start) begin
                phase_nx = CB_CAS_LEAD; t_load = 1'b1; t_val = TW'(CSR_CYC - 1);
            end
            CB_CAS_LEAD: if (t_zero) begin
                phase_nx = CB_BOTH_LOW; t_load = 1'b1; t_val = TW'(RAS_CYC - 1);
            end
            CB_BOTH_LOW: if (t_zero) begin
                phase_nx = CB_PRECHG; t_load = 1'b1; t_val = TW'(RP_CYC - 1);
            end
            CB_PRECHG: if (t_zero) begin
                if (left == '0) begin
                    phase_nx = CB_IDLE; done = 1'b1;
                end else begin
                    phase_nx = CB_CAS_LEAD; t_load = 1'b1; t_val = TW'(CSR_CYC - 1);
                end
            end
            default: phase_nx = CB_IDLE;
        endcase
    end

    // Phase register and remaining-refresh count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= CB_IDLE;
            left  <= '0;
        end else begin
            phase <= phase_nx;
            if (phase == CB_IDLE && start)                     left <= num;
            else if (phase == CB_PRECHG && t_zero && left != '0) left <= left - 1'b1;
        end
    end

    assign cas_n = !(phase == CB_CAS_LEAD || phase == CB_BOTH_LOW);
    assign ras_n = !(phase == CB_BOTH_LOW);
endmodule

// File: rtl/sr_sleep_seq.sv
// Self-refresh sleep sequencer: enters DRAM self-refresh on a sleep request and
// restores normal refresh on wake, with refresh work chosen by burst_mode.
// Assumes: one clock domain; durations given in clock cycles; all parameters >= 1.
module sr_sleep_seq
    import sr_pkg::*;
#(
    parameter int ROWS       = 1024,
    parameter int CSR_CYC    = 1,
    parameter int RAS_CYC    = 5,
    parameter int RP_CYC     = 3,
    parameter int SR_MIN_CYC = 10000,
    parameter int XRP_CYC    = 10,
    localparam int RW        = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int MAXD      = (SR_MIN_CYC > XRP_CYC) ? ((SR_MIN_CYC > CSR_CYC) ? SR_MIN_CYC : CSR_CYC)
                                                      : ((XRP_CYC > CSR_CYC) ? XRP_CYC : CSR_CYC),
    localparam int TW        = $clog2(MAXD + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep_req,
    input  logic wake_req,
    input  logic burst_mode,
    output logic ras_n,
    output logic cas_n,
    output logic we_n,
    output logic asleep,
    output logic awake,
    output logic ref_restart
);
    sr_state_t     st, st_nx;
    logic          burst_q, wake_pend;
    logic          t_load, t_zero;
    logic [TW-1:0] t_val;
    logic          eng_start, eng_done, eng_ras_n, eng_cas_n;
    logic [RW-1:0] eng_num;
    logic          leave_hold;

    sr_timer #(.W(TW)) u_tmr (
        .clk(clk), .rst_n(rst_n), .load(t_load), .value(t_val), .zero(t_zero)
    );

    sr_cbr_engine #(
        .ROWS(ROWS), .CSR_CYC(CSR_CYC), .RAS_CYC(RAS_CYC), .RP_CYC(RP_CYC)
    ) u_cbr (
        .clk(clk), .rst_n(rst_n), .start(eng_start), .num(eng_num),
        .ras_n(eng_ras_n), .cas_n(eng_cas_n), .done(eng_done)
    );

    assign leave_hold = (st == ST_HOLD) && t_zero && (wake_pend || wake_req);

    // Refresh bursts: full set before entry in burst mode; one or a full set after exit.
    assign eng_start = (st == ST_IDLE && sleep_req && burst_mode) ||
                       (st == ST_EXIT_PRE && t_zero);
    assign eng_num   = (st == ST_IDLE || burst_q) ? RW'(ROWS - 1) : '0;

    // Next-state and duration selection.
    always_comb begin
        st_nx  = st;
        t_load = 1'b0;
        t_val  = '0;
        unique case (st)
            ST_IDLE: if (sleep_req) begin
                if (burst_mode) st_nx = ST_PRE_BURST;
                else begin
                    st_nx = ST_ENTER; t_load = 1'b1; t_val = TW'(CSR_CYC - 1);
                end
            end
            ST_PRE_BURST: if (eng_done) begin
                st_nx = ST_ENTER; t_load = 1'b1; t_val = TW'(CSR_CYC - 1);
            end
            ST_ENTER: if (t_zero) begin
                st_nx = ST_HOLD; t_load = 1'b1; t_val = TW'(SR_MIN_CYC - 1);
            end
            ST_HOLD: if (leave_hold) begin
                st_nx = ST_EXIT_PRE; t_load = 1'b1; t_val = TW'(XRP_CYC - 1);
            end
            ST_EXIT_PRE: if (t_zero) st_nx = ST_POST_REF;
            ST_POST_REF: if (eng_done) st_nx = ST_IDLE;
            default:     st_nx = ST_IDLE;
        endcase
    end

    // State, latched mode, pending wake and restart pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st          <= ST_IDLE;
            burst_q     <= 1'b0;
            wake_pend   <= 1'b0;
            ref_restart <= 1'b0;
        end else begin
            st          <= st_nx;
            ref_restart <= (st == ST_POST_REF) && eng_done;
            if (st == ST_IDLE && sleep_req) burst_q <= burst_mode;
            if (st == ST_IDLE || leave_hold) wake_pend <= 1'b0;
            else if (wake_req)               wake_pend <= 1'b1;
        end
    end

    // Strobe selection: the engine owns the pins during refresh bursts.
    always_comb begin
        if (st == ST_PRE_BURST || st == ST_POST_REF) begin
            ras_n = eng_ras_n;
            cas_n = eng_cas_n;
        end else begin
            ras_n = (st != ST_HOLD);
            cas_n = !(st == ST_ENTER || st == ST_HOLD);
        end
    end

    assign we_n   = 1'b1;
    assign asleep = (st == ST_HOLD);
    assign awake  = (st == ST_IDLE);
endmodule

// File: rtl/sr_sleep_seq_chk.sv
// Assertion checker for sr_sleep_seq, attached with bind.
// Assumes: the parameters match those of the bound instance.
module sr_sleep_seq_chk #(
    parameter int SR_MIN_CYC = 10000,
    parameter int XRP_CYC    = 10
) (
    input logic clk,
    input logic rst_n,
    input logic ras_n,
    input logic cas_n,
    input logic asleep,
    input logic awake,
    input logic ref_restart
);
    logic [31:0] lo_cnt, hi_cnt;
    logic        asl_q, exit_flag;

    // Run lengths of asleep and of ras_n high, plus a marker for the exit window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_cnt    <= '0;
            hi_cnt    <= '0;
            asl_q     <= 1'b0;
            exit_flag <= 1'b0;
        end else begin
            lo_cnt <= asleep ? lo_cnt + 1 : '0;
            hi_cnt <= ras_n ? hi_cnt + 1 : '0;
            asl_q  <= asleep;
            if (asl_q && !asleep) exit_flag <= 1'b1;
            else if (!ras_n)      exit_flag <= 1'b0;
        end
    end

    a_r2_cbr_order: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> !cas_n);
    a_r4_min_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(asleep) |-> lo_cnt >= 32'(SR_MIN_CYC));
    a_r6_exit_precharge: assert property (@(posedge clk) disable iff (!rst_n)
        (exit_flag && $fell(ras_n)) |-> hi_cnt >= 32'(XRP_CYC));
    a_r6_joint_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(asleep) |-> (ras_n && cas_n));
    a_r9_asleep_pins: assert property (@(posedge clk) disable iff (!rst_n)
        asleep |-> (!ras_n && !cas_n && !awake));
    a_r9_awake_pins: assert property (@(posedge clk) disable iff (!rst_n)
        awake |-> (ras_n && cas_n));
    a_r10_restart_once: assert property (@(posedge clk) disable iff (!rst_n)
        ref_restart |=> !ref_restart);
    a_r10_restart_idle: assert property (@(posedge clk) disable iff (!rst_n)
        ref_restart |-> awake);
endmodule

bind sr_sleep_seq sr_sleep_seq_chk #(
    .SR_MIN_CYC(SR_MIN_CYC), .XRP_CYC(XRP_CYC)
) u_chk (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n),
    .asleep(asleep), .awake(awake), .ref_restart(ref_restart)
);

// File: tb/tb_sr_sleep_seq.sv
// Bench: builds the expected per-cycle pin trace from the requirements and
// compares it with the outputs after every clock edge.
module tb_sr_sleep_seq;
    localparam int ROWS = 4, CSR = 2, RAS = 5, RP = 3, SRMIN = 20, XRP = 10;
    localparam int PER  = CSR + RAS + RP;

    logic clk = 1'b0, rst_n = 1'b0;
    logic sleep_req = 1'b0, wake_req = 1'b0, burst_mode = 1'b0;
    logic ras_n, cas_n, we_n, asleep, awake, ref_restart;
    int   compared = 0, mismatched = 0;

    logic [5:0] exp_q[$];
    string      tag_q[$];

    always #5 clk = ~clk;

    sr_sleep_seq #(
        .ROWS(ROWS), .CSR_CYC(CSR), .RAS_CYC(RAS), .RP_CYC(RP),
        .SR_MIN_CYC(SRMIN), .XRP_CYC(XRP)
    ) dut (
        .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .wake_req(wake_req),
        .burst_mode(burst_mode), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .asleep(asleep), .awake(awake), .ref_restart(ref_restart)
    );

    // Expected vector order: {ras_n, cas_n, we_n, asleep, awake, ref_restart}; we_n always 1 (R11).
    task automatic push(logic r, logic c, logic s, logic a, logic x, int n, string t);
        repeat (n) begin
            exp_q.push_back({r, c, 1'b1, s, a, x});
            tag_q.push_back(t);
        end
    endtask

    task automatic push_cbr(int n, string t);
        for (int i = 0; i < n; i++) begin
            push(1, 0, 0, 0, 0, CSR, t);
            push(0, 0, 0, 0, 0, RAS, t);
            push(1, 1, 0, 0, 0, RP, t);
        end
    endtask

    function automatic int hold_start(bit mode);
        return mode ? ROWS * PER + CSR : CSR;
    endfunction

    // Full sleep/wake trace; w = trace index at whose edge wake_req is sampled.
    task automatic build(bit mode, int w);
        int h0, hold;
        h0   = hold_start(mode);
        hold = (w - h0 > SRMIN) ? (w - h0) : SRMIN;
        if (mode) push_cbr(ROWS, "R3 pre-entry burst");
        push(1, 0, 0, 0, 0, CSR, "R2 entry CBR order");
        push(0, 0, 1, 0, 0, hold, "R4 R5 R9 self-refresh hold");
        push(1, 1, 0, 0, 0, XRP, "R6 exit precharge");
        if (mode) push_cbr(ROWS, "R8 exit burst");
        else      push_cbr(1, "R7 single exit CBR");
        push(1, 1, 0, 1, 1, 1, "R10 restart pulse");
        push(1, 1, 0, 1, 0, 2, "R9 R11 idle after wake");
    endtask

    // Drive inputs per cycle and compare each trace entry 2 ns after its edge.
    task automatic play(bit mode, int sleep_at, int wake_at, int extra_sleep);
        int n;
        logic [5:0] got, exp;
        string t;
        n = exp_q.size();
        for (int k = 0; k < n; k++) begin
            sleep_req  = (k == sleep_at) || (k == extra_sleep);
            wake_req   = (k == wake_at);
            burst_mode = (k <= sleep_at) ? mode : !mode;   // R12: later changes ignored
            @(posedge clk);
            #2;
            exp = exp_q.pop_front();
            t   = tag_q.pop_front();
            got = {ras_n, cas_n, we_n, asleep, awake, ref_restart};
            compared++;
            if (got !== exp) begin
                mismatched++;
                $display("FAIL %s cycle %0d: got %b expected %b", t, k, got, exp);
            end
        end
        sleep_req = 1'b0;
        wake_req  = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        // R1: values held in reset
        compared++;
        if ({ras_n, cas_n, we_n, asleep, awake, ref_restart} !== 6'b111010) begin
            mismatched++;
            $display("FAIL R1 reset: got %b expected %b",
                     {ras_n, cas_n, we_n, asleep, awake, ref_restart}, 6'b111010);
        end
        rst_n = 1'b1;
        push(1, 1, 0, 1, 0, 3, "R1 idle after reset");
        play(0, -1, -1, -1);

        // Distributed mode, early wake held pending (R2 R4 R7).
        build(0, 3);
        play(0, 0, 3, -1);

        // Burst mode, late wake, stray sleep_req mid-sequence (R3 R5 R8 R12).
        build(1, hold_start(1) + SRMIN + 7);
        play(1, 0, hold_start(1) + SRMIN + 7, 5);

        // Wake boundary around the end of the minimum hold (R4 R5).
        build(0, hold_start(0) + SRMIN - 1);
        play(0, 0, hold_start(0) + SRMIN - 1, -1);
        build(0, hold_start(0) + SRMIN);
        play(0, 0, hold_start(0) + SRMIN, -1);
        build(0, hold_start(0) + SRMIN + 1);
        play(0, 0, hold_start(0) + SRMIN + 1, -1);

        // R12: wake while idle leaves no pending wake, so the next hold waits for a fresh wake.
        push(1, 1, 0, 1, 0, 3, "R12 wake while idle");
        play(0, -1, 1, -1);
        build(0, hold_start(0) + SRMIN + 25);
        play(0, 0, hold_start(0) + SRMIN + 25, -1);

        // Burst mode with early wake (R3 R4 R8).
        build(1, 2);
        play(1, 0, 2, -1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule